// File: doc/BRIEF.md
# Interrupt Map and Gating Unit

The block sits between a set of level-sensitive interrupt sources and the interrupt controller that follows them. It takes 32 incoming interrupt lines and passes each one onward only when the mapping register that governs it is enabled. Eight mapping registers each govern four consecutive lines, so one enable bit opens or closes a group of four. Each register also carries a fixed identifier that software reads back to learn which group it is looking at. The enable bit is the only field that software can write.

Software reaches the registers through a simple synchronous slave port: a one-cycle write strobe with address and data, and read data returned combinationally for whatever offset is on the address lines. Each register sits in an 8-byte slot, and only the upper word of the slot is live. A small index calculator sits beside the registers. From a device/function number and an interrupt pin number it gives the input line that a device on the host bus drives, and the line that a device behind a secondary bridge drives. Integration logic uses these to wire sources to the 32 inputs.

Top module: `irq_gate_map`

## Requirements
- R1: After reset every enable bit is 0 and `irq_out` is all zeros. A read at offset `8*i+4` returns `0x000007C0 | (i << 2)`: bits 10:6 hold 0x1F, bits 4:2 hold the register number, and bit 31 (the enable) is clear.
- R2: A write with `wr_en` high to an offset with address bit 2 set loads bit 31 of `wdata` into that register's enable bit. Bits 30:0 of the register keep their identifier value whatever `wdata` carries.
- R3: When address bit 2 is 0 (the lower word of a slot), reads return 0 and writes change no register.
- R4: Address bits 5:3 select the register, so offsets 0x04, 0x0C, ..., 0x3C reach registers 0 to 7 in turn.
- R5: Output line n is registered. One clock after a rising edge, it equals input line n if the enable bit of register n>>2 is 1, and it is 0 otherwise.
- R6: An enable bit governs exactly its own four lines and has no effect on the other 28.
- R7: Asserting `rst` for one clock while enables are set clears every enable bit and drives `irq_out` to zero. The identifiers read back unchanged.
- R8: `host_idx`, registered with one cycle of latency, equals `pin + 16` when bit 0 of `dev_fn` is 1, and `pin` otherwise.
- R9: `bridge_idx`, registered with one cycle of latency, equals `((dev_fn & 0x18) >> 1) + pin`.
- R10: A change on an input line or on an enable bit does not show on `irq_out` in the cycle it is made. It shows after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 6 | Byte offset within the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed offset (combinational) |
| irq_in | input | 32 | Incoming level-sensitive interrupt lines |
| irq_out | output | 32 | Gated interrupt lines, registered |
| dev_fn | input | 8 | Device/function number of a source |
| dev_pin | input | 2 | Interrupt pin number of a source (0 to 3) |
| host_idx | output | 5 | Input line used by a host-bus device |
| bridge_idx | output | 5 | Input line used by a device behind a secondary bridge |

## Verification
The bench builds the block with its default parameters: eight registers of four lines each, giving 32 lines and a 6-bit window. This brings every register slot, both words of each slot, the top line 31 and the +16 host offset within reach. Gating patterns are chosen so that an open group sits next to closed groups, which exposes any enable that leaks into a neighbour. The one-cycle latency of the outputs is checked both in the cycle an input changes and in the cycle after it.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

  // Width of the read-only identifier field below the enable bit.
  localparam int unsigned IDENT_W = 31;

  // Fixed identifier held in bits 30:0 of mapping register idx:
  // 0x1F in bits 10:6 and the register number in bits 4:2.
  function automatic logic [IDENT_W-1:0] map_ident(input int unsigned idx);
    logic [IDENT_W-1:0] v;
    v       = '0;
    v[10:6] = 5'h1F;
    v[4:2]  = idx[2:0];
    return v;
  endfunction

endpackage

// File: rtl/irqmap_regs.sv
module irqmap_regs #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_REGS-1:0] en_vec
);
  import irqmap_pkg::*;

  localparam int unsigned IDX_W  = $clog2(NUM_REGS);
  localparam int unsigned IDX_LO = 3;
  localparam int unsigned EN_BIT = DATA_W - 1;
  localparam int unsigned WIN_SH = IDX_W + IDX_LO;

  logic [IDX_W-1:0] sel;
  logic             upper_word;
  logic             in_window;

  assign sel        = addr[IDX_LO +: IDX_W];
  assign upper_word = addr[2];
  assign in_window  = ((addr >> WIN_SH) == '0);

  // Enable bits: the only writable storage in the block.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_vec <= '0;
    end else if (wr_en && upper_word && in_window) begin
      en_vec[sel] <= wdata[EN_BIT];
    end
  end

  // Combinational read port.
  always_comb begin
    rdata = '0;
    if (upper_word && in_window) begin
      rdata[EN_BIT]      = en_vec[sel];
      rdata[IDENT_W-1:0] = map_ident(32'(sel));
    end
  end

endmodule

// File: rtl/irqmap_gate.sv
module irqmap_gate #(
  parameter int unsigned NUM_REGS      = 8,
  parameter int unsigned LINES_PER_REG = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_REGS-1:0]               en_vec,
  input  logic [NUM_REGS*LINES_PER_REG-1:0] irq_in,
  output logic [NUM_REGS*LINES_PER_REG-1:0] irq_out
);
  localparam int unsigned NUM_LINES = NUM_REGS * LINES_PER_REG;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        irq_out[n] <= 1'b0;
      end else begin
        irq_out[n] <= irq_in[n] & en_vec[n / LINES_PER_REG];
      end
    end
  end

endmodule

// File: rtl/irqmap_index.sv
module irqmap_index #(
  parameter int unsigned NUM_LINES     = 32,
  parameter int unsigned LINES_PER_REG = 4,
  parameter int unsigned FN_W          = 8,
  parameter int unsigned PIN_W         = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [FN_W-1:0]              dev_fn,
  input  logic [PIN_W-1:0]             dev_pin,
  output logic [$clog2(NUM_LINES)-1:0] host_idx,
  output logic [$clog2(NUM_LINES)-1:0] bridge_idx
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);
  localparam int unsigned HALF  = NUM_LINES / 2;

  logic [IDX_W-1:0] host_nxt;
  logic [IDX_W-1:0] bridge_nxt;

  always_comb begin
    host_nxt   = IDX_W'(dev_pin) + (dev_fn[0] ? IDX_W'(HALF) : '0);
    bridge_nxt = IDX_W'(dev_pin) + IDX_W'(dev_fn[4:3]) * IDX_W'(LINES_PER_REG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_idx   <= '0;
      bridge_idx <= '0;
    end else begin
      host_idx   <= host_nxt;
      bridge_idx <= bridge_nxt;
    end
  end

endmodule

// File: rtl/irq_gate_map.sv
module irq_gate_map #(
  parameter int unsigned NUM_REGS      = 8,
  parameter int unsigned LINES_PER_REG = 4,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned ADDR_W        = 6,
  parameter int unsigned FN_W          = 8,
  parameter int unsigned PIN_W         = 2,
  localparam int unsigned NUM_LINES    = NUM_REGS * LINES_PER_REG,
  localparam int unsigned LIDX_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out,
  input  logic [FN_W-1:0]      dev_fn,
  input  logic [PIN_W-1:0]     dev_pin,
  output logic [LIDX_W-1:0]    host_idx,
  output logic [LIDX_W-1:0]    bridge_idx
);

  logic [NUM_REGS-1:0] en_vec;

  irqmap_regs #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .en_vec (en_vec)
  );

  irqmap_gate #(
    .NUM_REGS      (NUM_REGS),
    .LINES_PER_REG (LINES_PER_REG)
  ) u_gate (
    .clk     (clk),
    .rst     (rst),
    .en_vec  (en_vec),
    .irq_in  (irq_in),
    .irq_out (irq_out)
  );

  irqmap_index #(
    .NUM_LINES     (NUM_LINES),
    .LINES_PER_REG (LINES_PER_REG),
    .FN_W          (FN_W),
    .PIN_W         (PIN_W)
  ) u_index (
    .clk        (clk),
    .rst        (rst),
    .dev_fn     (dev_fn),
    .dev_pin    (dev_pin),
    .host_idx   (host_idx),
    .bridge_idx (bridge_idx)
  );

endmodule

// File: rtl/irq_gate_map_chk.sv
module irq_gate_map_chk #(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic [NUM_LINES-1:0] irq_in,
  input logic [NUM_LINES-1:0] irq_out,
  input logic [NUM_REGS-1:0]  en_vec
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  // R3: lower word of a slot always reads zero
  a_r3_lower_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !addr[2] |-> (rdata == '0));

  // R3: a lower-word write leaves every enable as it was
  a_r3_lower_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr[2]) |=> (en_vec == $past(en_vec)));

  // R2: an upper-word write lands in the enable bit of the addressed register
  a_r2_enable_loaded: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[2]) |=> (en_vec[$past(addr[IDX_W+2:3])] == $past(wdata[DATA_W-1])));

  // R2: identifier bits never change for an unchanged address
  a_r2_ident_stable: assert property (@(posedge clk) disable iff (rst)
    (addr == $past(addr)) |-> (rdata[DATA_W-2:0] == $past(rdata[DATA_W-2:0])));

  // R5: an output line is never high unless its input was high a cycle before
  a_r5_no_spurious_out: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & ~$past(irq_in)) == '0));

  // R7: the first cycle out of reset has all outputs low and all enables clear
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((irq_out == '0) && (en_vec == '0)));

endmodule

bind irq_gate_map irq_gate_map_chk #(
  .NUM_REGS  (NUM_REGS),
  .NUM_LINES (NUM_LINES),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq_in  (irq_in),
  .irq_out (irq_out),
  .en_vec  (en_vec)
);

// File: tb/irq_gate_map_bench.sv
`timescale 1ns/1ps
module irq_gate_map_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] irq_in = '0;
  logic [31:0] irq_out;
  logic [7:0]  dev_fn = '0;
  logic [1:0]  dev_pin = '0;
  logic [4:0]  host_idx;
  logic [4:0]  bridge_idx;

  always #10 clk = ~clk;

  irq_gate_map u_irq_gate_map (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .irq_in     (irq_in),
    .irq_out    (irq_out),
    .dev_fn     (dev_fn),
    .dev_pin    (dev_pin),
    .host_idx   (host_idx),
    .bridge_idx (bridge_idx)
  );

  localparam int SEL_RD = 0, SEL_OUT = 1, SEL_HOST = 2, SEL_BR = 3;

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t       q[$];
  item_t       cur;
  logic [31:0] obs;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  // Monitor: compares queued expectations half a cycle after the edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      cur = q.pop_front();
      case (cur.sel)
        SEL_RD:   obs = rdata;
        SEL_OUT:  obs = irq_out;
        SEL_HOST: obs = {27'd0, host_idx};
        default:  obs = {27'd0, bridge_idx};
      endcase
      checks++;
      if (obs !== cur.exp) begin
        errors++;
        $display("FAIL %s actual=%08h expected=%08h", cur.tag, obs, cur.exp);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_val(input string tag, input int sel, input logic [31:0] exp);
    item_t it;
    it.tag = tag;
    it.sel = sel;
    it.exp = exp;
    q.push_back(it);
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    expect_val(tag, SEL_RD, exp);
    step();
  endtask

  function automatic logic [31:0] ident(input int i);
    return 32'h7C0 | (32'(i) << 2);
  endfunction

  initial begin
    step();
    step();
    rst = 1'b0;
    irq_in = 32'hFFFF_FFFF;
    step();

    // R1: reset values and closed gates
    expect_val("R1 irq_out after reset", SEL_OUT, 32'h0);
    // R4: each slot's upper word reaches its register
    for (int i = 0; i < 8; i++) begin
      read_chk("R1 R4 reset ident read", 6'(i*8 + 4), ident(i));
    end
    // R3: lower words read zero
    for (int i = 0; i < 8; i++) begin
      read_chk("R3 lower word read", 6'(i*8), 32'h0);
    end

    // R2: enable loads, identifier untouched
    reg_write(6'h14, 32'hFFFF_FFFF);
    read_chk("R2 enable set reg2", 6'h14, 32'h8000_0000 | ident(2));
    reg_write(6'h1C, 32'h7FFF_FFFF);
    read_chk("R2 enable clear reg3", 6'h1C, ident(3));

    // R3: lower-word write ignored, seen through read and outputs
    reg_write(6'h28, 32'hFFFF_FFFF);
    read_chk("R3 lower write ignored reg5", 6'h2C, ident(5));
    expect_val("R3 R6 only group2 open", SEL_OUT, 32'h0000_0F00);

    // R5 R6: one group open, patterned input
    irq_in = 32'hA5A5_A5A5;
    step();
    expect_val("R5 R6 pattern A5 through group2", SEL_OUT, 32'h0000_0500);

    // R10: change not visible in the same cycle
    irq_in = 32'h0000_0A00;
    #1;
    expect_val("R10 same-cycle output unchanged", SEL_OUT, 32'h0000_0500);
    step();
    expect_val("R10 next-cycle output updated", SEL_OUT, 32'h0000_0A00);

    // R5: open all groups
    for (int i = 0; i < 8; i++) begin
      reg_write(6'(i*8 + 4), 32'h8000_0000);
    end
    irq_in = 32'h1234_5678;
    step();
    expect_val("R5 all open", SEL_OUT, 32'h1234_5678);

    // R10 R6: closing reg0 takes effect one cycle after the write edge
    addr  = 6'h04;
    wdata = 32'h0;
    wr_en = 1'b1;
    #1;
    expect_val("R10 enable write not yet seen", SEL_OUT, 32'h1234_5678);
    step();
    wr_en = 1'b0;
    #1;
    expect_val("R10 enable just latched, output old", SEL_OUT, 32'h1234_5678);
    step();
    expect_val("R6 reg0 closed lines 3:0 only", SEL_OUT, 32'h1234_5670);

    // R5: top group with line 31
    irq_in = 32'hF000_0000;
    reg_write(6'h3C, 32'h0);
    step();
    expect_val("R5 top group closed", SEL_OUT, 32'h0);
    reg_write(6'h3C, 32'h8000_0000);
    step();
    expect_val("R5 top group open", SEL_OUT, 32'hF000_0000);

    // R7: reset with enables set
    irq_in = 32'hFFFF_FFFF;
    rst = 1'b1;
    step();
    rst = 1'b0;
    expect_val("R7 outputs low after reset", SEL_OUT, 32'h0);
    read_chk("R7 reg7 enable cleared", 6'h3C, ident(7));
    read_chk("R7 reg1 enable cleared", 6'h0C, ident(1));
    step();
    expect_val("R7 outputs stay low", SEL_OUT, 32'h0);

    // R8 R9: index calculation
    dev_fn = 8'h01; dev_pin = 2'd2;
    step();
    expect_val("R8 host fn0 set", SEL_HOST, 32'd18);
    expect_val("R9 bridge fn 01", SEL_BR, 32'd2);
    dev_fn = 8'h08; dev_pin = 2'd3;
    step();
    expect_val("R8 host fn0 clear", SEL_HOST, 32'd3);
    expect_val("R9 bridge fn 08", SEL_BR, 32'd7);
    dev_fn = 8'h18; dev_pin = 2'd3;
    step();
    expect_val("R9 bridge max", SEL_BR, 32'd15);
    dev_fn = 8'hFF; dev_pin = 2'd3;
    step();
    expect_val("R8 host max", SEL_HOST, 32'd19);
    expect_val("R9 bridge fn FF", SEL_BR, 32'd15);
    dev_fn = 8'h11; dev_pin = 2'd0;
    #1;
    expect_val("R8 host latency old", SEL_HOST, 32'd19);
    step();
    expect_val("R9 bridge fn 11", SEL_BR, 32'd8);
    expect_val("R8 host fn 11", SEL_HOST, 32'd16);

    step();
    step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule